// File: doc/BRIEF.md
# Single-Bus Processor Step Sequencer

This block is the hardwired control unit of a non-pipelined 32-bit processor whose registers share one data bus. It keeps a 3-bit time-step counter and, from the current step, the opcode held in the instruction register, and a few datapath flags, it drives a 30-bit word of register-transfer strobes. Each strobe gates a register onto the bus, loads a register from the bus or selects an ALU function. The datapath, ALU and memory sit outside the block and only obey the word.

Every instruction begins with the same three fetch steps. The block stalls on memory handshakes and repeats one step for serial shifts. A soft reset request clears the program counter and returns the sequencer to fetch from whatever step it is in. It sequences register add, immediate add, store, shift right and conditional branch. Any other opcode finishes at once.

Top module: `ctl_seq_top`

## Requirements
- R1: Bit map of ctl_o: 0 pc_out, 1 ma_in, 2 inc4, 3 c_in, 4 mem_rd, 5 c_out, 6 pc_in, 7 mem_wait, 8 md_out, 9 ir_in, 10 sel_ra, 11 sel_rb, 12 sel_rc, 13 reg_out, 14 base_out, 15 reg_in, 16 a_in, 17 imm2_out, 18 imm1_out, 19 alu_add, 20 alu_shr, 21 alu_pass, 22 cnt_load, 23 cnt_dec, 24 cond_load, 25 md_in, 26 mem_wr, 27 seq_end, 28 clr_pc, 29 clr_rst. Fetch is opcode-independent: step 0 drives bits {0,1,2,3,4}, step 1 drives {5,6,7} and step 2 drives {8,9}.
- R2: While mem_wait is high and mem_done_i is low, the step does not change and the same word repeats next cycle.
- R3: Opcode 12 (register add) drives {11,13,16} at step 3, {12,13,19,3} at step 4 and {5,10,15,27} at step 5. Opcode 13 (immediate add) is identical except that step 4 drives {17,19,3}.
- R4: Opcode 3 (store) drives {11,14,16} at step 3, {17,19,3} at step 4, {1,5} at step 5, {10,13,25,26} at step 6 and {7,27} at step 7. It holds step 7 until mem_done_i.
- R5: Opcode 26 (shift right) drives {18,22} at step 3 and {12,13,22} at step 4 only when n_zero_i is high. It drives {11,13,21,3} at step 5. At step 6 with n_zero_i low it drives {5,20,3,23} and stays at step 6. With n_zero_i high it drives nothing and moves on. Step 7 drives {5,10,15,27}.
- R6: Opcode 8 (branch) drives {12,13,24} at step 3 and {11,13,27} at step 4, plus pc_in only when cond_i is high.
- R7: When seq_end is driven and no stall holds, the next cycle is step 0 (fetch word of R1).
- R8: soft_rst_i high in a cycle makes the next cycle's word exactly {28,29}, in any step and for any opcode. The cycle after that is step 0.
- R9: rst is synchronous. While it is high ctl_o is zero, and the first cycle after it is step 0.
- R10: Any opcode not listed in R3 to R6 drives only seq_end at step 3.
- R11: At most one of sel_ra, sel_rb, sel_rc is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous external reset, active high |
| soft_rst_i | input | 1 | Soft reset request, captured each cycle |
| opcode_i | input | 5 | Opcode field of the instruction register |
| mem_done_i | input | 1 | Memory completion handshake |
| n_zero_i | input | 1 | Shift counter equals zero |
| cond_i | input | 1 | Branch condition flag |
| ctl_o | output | 30 | Register-transfer strobe word, bit map in R1 |

## Verification
Directed runs take each opcode through its full sequence. Memory completion is delayed so that stalls at step 1 and at the store's step 7 become visible. The shift counter flag stays low for several cycles, which separates the repeated step 6 from a single pass. The branch runs with the condition both set and clear to separate a taken branch from one that is not taken. A soft reset lands in the middle of a store. Constrained random traffic then mixes opcodes, irregular completion, flag values and sparse soft resets. An independent bench model predicts every cycle's word, so a wrong step advance shows as a word mismatch in the next cycle.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
    localparam int STEP_W = 3;
    localparam int OPC_W  = 5;
    localparam int CTL_W  = 30;

    localparam int B_PC_OUT   = 0;
    localparam int B_MA_IN    = 1;
    localparam int B_INC4     = 2;
    localparam int B_C_IN     = 3;
    localparam int B_MEM_RD   = 4;
    localparam int B_C_OUT    = 5;
    localparam int B_PC_IN    = 6;
    localparam int B_MEM_WAIT = 7;
    localparam int B_MD_OUT   = 8;
    localparam int B_IR_IN    = 9;
    localparam int B_SEL_RA   = 10;
    localparam int B_SEL_RB   = 11;
    localparam int B_SEL_RC   = 12;
    localparam int B_REG_OUT  = 13;
    localparam int B_BASE_OUT = 14;
    localparam int B_REG_IN   = 15;
    localparam int B_A_IN     = 16;
    localparam int B_IMM2_OUT = 17;
    localparam int B_IMM1_OUT = 18;
    localparam int B_ALU_ADD  = 19;
    localparam int B_ALU_SHR  = 20;
    localparam int B_ALU_PASS = 21;
    localparam int B_CNT_LOAD = 22;
    localparam int B_CNT_DEC  = 23;
    localparam int B_COND_LD  = 24;
    localparam int B_MD_IN    = 25;
    localparam int B_MEM_WR   = 26;
    localparam int B_SEQ_END  = 27;
    localparam int B_CLR_PC   = 28;
    localparam int B_CLR_RST  = 29;

    localparam logic [OPC_W-1:0] OP_ST   = 5'd3;
    localparam logic [OPC_W-1:0] OP_BR   = 5'd8;
    localparam logic [OPC_W-1:0] OP_ADD  = 5'd12;
    localparam logic [OPC_W-1:0] OP_ADDI = 5'd13;
    localparam logic [OPC_W-1:0] OP_SHR  = 5'd26;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        step_t step;
        logic  rflag;
    } seq_state_t;
endpackage

// File: rtl/ctl_seq_step.sv
module ctl_seq_step
    import ctl_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst_i,
    input  logic  wait_i,
    input  logic  done_i,
    input  logic  end_i,
    input  logic  loop_i,
    output step_t step_q,
    output logic  rflag_q
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rflag = soft_rst_i;
        if (st_q.rflag)
            st_d.step = '0;
        else if (wait_i && !done_i)
            st_d.step = st_q.step;
        else if (end_i)
            st_d.step = '0;
        else if (loop_i)
            st_d.step = st_q.step;
        else
            st_d.step = st_q.step + step_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign step_q  = st_q.step;
    assign rflag_q = st_q.rflag;

    // R2
    wait_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_i && !done_i && !rflag_q) |=> (step_q == $past(step_q)));

    // R7
    end_return_chk: assert property (@(posedge clk) disable iff (rst)
        (end_i && !rflag_q && (!wait_i || done_i)) |=> (step_q == '0));

    // R8
    soft_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        rflag_q |=> (step_q == '0));
endmodule

// File: rtl/ctl_seq_enc.sv
module ctl_seq_enc
    import ctl_seq_pkg::*;
(
    input  step_t            step_i,
    input  logic             rflag_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             n_zero_i,
    input  logic             cond_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             loop_o
);
    logic [CTL_W-1:0] c;

    always_comb begin
        c = '0;
        if (rflag_i) begin
            c[B_CLR_PC]  = 1'b1;
            c[B_CLR_RST] = 1'b1;
        end else begin
            case (step_i)
                3'd0: begin
                    c[B_PC_OUT] = 1'b1; c[B_MA_IN] = 1'b1; c[B_INC4] = 1'b1;
                    c[B_C_IN] = 1'b1;   c[B_MEM_RD] = 1'b1;
                end
                3'd1: begin
                    c[B_C_OUT] = 1'b1; c[B_PC_IN] = 1'b1; c[B_MEM_WAIT] = 1'b1;
                end
                3'd2: begin
                    c[B_MD_OUT] = 1'b1; c[B_IR_IN] = 1'b1;
                end
                default: begin
                    case (opcode_i)
                        OP_ADD, OP_ADDI: begin
                            case (step_i)
                                3'd3: begin
                                    c[B_SEL_RB] = 1'b1; c[B_REG_OUT] = 1'b1; c[B_A_IN] = 1'b1;
                                end
                                3'd4: begin
                                    if (opcode_i == OP_ADD) begin
                                        c[B_SEL_RC] = 1'b1; c[B_REG_OUT] = 1'b1;
                                    end else begin
                                        c[B_IMM2_OUT] = 1'b1;
                                    end
                                    c[B_ALU_ADD] = 1'b1; c[B_C_IN] = 1'b1;
                                end
                                3'd5: begin
                                    c[B_C_OUT] = 1'b1; c[B_SEL_RA] = 1'b1;
                                    c[B_REG_IN] = 1'b1; c[B_SEQ_END] = 1'b1;
                                end
                                default: c = '0;
                            endcase
                        end
                        OP_ST: begin
                            case (step_i)
                                3'd3: begin
                                    c[B_SEL_RB] = 1'b1; c[B_BASE_OUT] = 1'b1; c[B_A_IN] = 1'b1;
                                end
                                3'd4: begin
                                    c[B_IMM2_OUT] = 1'b1; c[B_ALU_ADD] = 1'b1; c[B_C_IN] = 1'b1;
                                end
                                3'd5: begin
                                    c[B_C_OUT] = 1'b1; c[B_MA_IN] = 1'b1;
                                end
                                3'd6: begin
                                    c[B_SEL_RA] = 1'b1; c[B_REG_OUT] = 1'b1;
                                    c[B_MD_IN] = 1'b1;  c[B_MEM_WR] = 1'b1;
                                end
                                default: begin
                                    c[B_MEM_WAIT] = 1'b1; c[B_SEQ_END] = 1'b1;
                                end
                            endcase
                        end
                        OP_SHR: begin
                            case (step_i)
                                3'd3: begin
                                    c[B_IMM1_OUT] = 1'b1; c[B_CNT_LOAD] = 1'b1;
                                end
                                3'd4: begin
                                    if (n_zero_i) begin
                                        c[B_SEL_RC] = 1'b1; c[B_REG_OUT] = 1'b1;
                                        c[B_CNT_LOAD] = 1'b1;
                                    end
                                end
                                3'd5: begin
                                    c[B_SEL_RB] = 1'b1; c[B_REG_OUT] = 1'b1;
                                    c[B_ALU_PASS] = 1'b1; c[B_C_IN] = 1'b1;
                                end
                                3'd6: begin
                                    if (!n_zero_i) begin
                                        c[B_C_OUT] = 1'b1; c[B_ALU_SHR] = 1'b1;
                                        c[B_C_IN] = 1'b1;  c[B_CNT_DEC] = 1'b1;
                                    end
                                end
                                default: begin
                                    c[B_C_OUT] = 1'b1; c[B_SEL_RA] = 1'b1;
                                    c[B_REG_IN] = 1'b1; c[B_SEQ_END] = 1'b1;
                                end
                            endcase
                        end
                        OP_BR: begin
                            case (step_i)
                                3'd3: begin
                                    c[B_SEL_RC] = 1'b1; c[B_REG_OUT] = 1'b1; c[B_COND_LD] = 1'b1;
                                end
                                3'd4: begin
                                    c[B_SEL_RB] = 1'b1; c[B_REG_OUT] = 1'b1;
                                    c[B_SEQ_END] = 1'b1; c[B_PC_IN] = cond_i;
                                end
                                default: c = '0;
                            endcase
                        end
                        default: c[B_SEQ_END] = (step_i == 3'd3);
                    endcase
                end
            endcase
        end
    end

    assign ctl_o  = c;
    assign loop_o = !rflag_i && (opcode_i == OP_SHR) && (step_i == 3'd6) && !n_zero_i;
endmodule

// File: rtl/ctl_seq_top.sv
module ctl_seq_top
    import ctl_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst_i,
    input  logic [4:0]       opcode_i,
    input  logic             mem_done_i,
    input  logic             n_zero_i,
    input  logic             cond_i,
    output logic [CTL_W-1:0] ctl_o
);
    step_t            step_q;
    logic             rflag_q;
    logic             loop_w;
    logic [CTL_W-1:0] enc_w;

    ctl_seq_step u_step (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst_i),
        .wait_i     (enc_w[B_MEM_WAIT]),
        .done_i     (mem_done_i),
        .end_i      (enc_w[B_SEQ_END]),
        .loop_i     (loop_w),
        .step_q     (step_q),
        .rflag_q    (rflag_q)
    );

    ctl_seq_enc u_enc (
        .step_i   (step_q),
        .rflag_i  (rflag_q),
        .opcode_i (opcode_i),
        .n_zero_i (n_zero_i),
        .cond_i   (cond_i),
        .ctl_o    (enc_w),
        .loop_o   (loop_w)
    );

    assign ctl_o = rst ? '0 : enc_w;

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (ctl_o[B_CLR_PC] && ctl_o[B_CLR_RST] && ($countones(ctl_o) == 2)));

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_o[B_SEL_RA], ctl_o[B_SEL_RB], ctl_o[B_SEL_RC]}));

    // R5
    dec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o[B_CNT_DEC] |-> !n_zero_i);
endmodule

// File: tb/ctl_seq_top_test.sv
`timescale 1ns/1ps
module ctl_seq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst_i = 1'b0;
    logic [4:0]  opcode_i = 5'd0;
    logic        mem_done_i = 1'b0;
    logic        n_zero_i = 1'b0;
    logic        cond_i = 1'b0;
    logic [29:0] ctl_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int m_step = 0;
    bit m_rf = 1'b0;
    bit prev_end = 1'b0;
    bit prev_stall = 1'b0;

    always #2 clk = ~clk;

    ctl_seq_top uut (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .opcode_i(opcode_i),
        .mem_done_i(mem_done_i), .n_zero_i(n_zero_i), .cond_i(cond_i), .ctl_o(ctl_o)
    );

    function automatic logic [29:0] bits(input int a, input int b = -1, input int c = -1,
                                         input int d = -1, input int e = -1);
        logic [29:0] v = '0;
        v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        if (d >= 0) v[d] = 1'b1;
        if (e >= 0) v[e] = 1'b1;
        return v;
    endfunction

    function automatic logic [29:0] exp_ctl(input bit r, input bit rf, input int s,
                                            input int op, input bit nz, input bit cd);
        if (r) return '0;
        if (rf) return bits(28, 29);
        case (s)
            0: return bits(0, 1, 2, 3, 4);
            1: return bits(5, 6, 7);
            2: return bits(8, 9);
            default: ;
        endcase
        if (op == 12 || op == 13) begin
            if (s == 3) return bits(11, 13, 16);
            if (s == 4) return (op == 12) ? bits(12, 13, 19, 3) : bits(17, 19, 3);
            if (s == 5) return bits(5, 10, 15, 27);
            return '0;
        end
        if (op == 3) begin
            case (s)
                3: return bits(11, 14, 16);
                4: return bits(17, 19, 3);
                5: return bits(5, 1);
                6: return bits(10, 13, 25, 26);
                default: return bits(7, 27);
            endcase
        end
        if (op == 26) begin
            case (s)
                3: return bits(18, 22);
                4: return nz ? bits(12, 13, 22) : '0;
                5: return bits(11, 13, 21, 3);
                6: return nz ? '0 : bits(5, 20, 3, 23);
                default: return bits(5, 10, 15, 27);
            endcase
        end
        if (op == 8) begin
            if (s == 3) return bits(12, 13, 24);
            if (s == 4) return cd ? bits(11, 13, 27, 6) : bits(11, 13, 27);
            return '0;
        end
        return (s == 3) ? bits(27) : '0;
    endfunction

    function automatic string tag_of(input bit r, input int s, input int op);
        if (r) return "R9";
        if (m_rf) return "R8";
        if (prev_end) return "R7";
        if (prev_stall) return "R2";
        if (s < 3) return "R1";
        if (op == 12 || op == 13) return "R3";
        if (op == 3) return "R4";
        if (op == 26) return "R5";
        if (op == 8) return "R6";
        return "R10";
    endfunction

    task automatic cyc(input bit r, input int op, input bit dn, input bit nz,
                       input bit cd, input bit sr);
        logic [29:0] e;
        string t;
        bit stall;
        @(negedge clk);
        rst = r; opcode_i = 5'(op); mem_done_i = dn; n_zero_i = nz;
        cond_i = cd; soft_rst_i = sr;
        #1;
        e = exp_ctl(r, m_rf, m_step, op, nz, cd);
        t = tag_of(r, m_step, op);
        checks++;
        if (ctl_o !== e) begin
            fails++;
            $display("FAIL %s step=%0d op=%0d actual=%h expected=%h", t, m_step, op, ctl_o, e);
        end
        checks++;
        if ($countones(ctl_o[12:10]) > 1) begin
            fails++;
            $display("FAIL R11 selects actual=%b expected=at most one", ctl_o[12:10]);
        end
        stall = !r && !m_rf && e[7] && !dn;
        prev_end = !r && !m_rf && e[27] && !stall;
        prev_stall = stall;
        if (r) begin
            m_step = 0; m_rf = 1'b0;
        end else begin
            if (m_rf) m_step = 0;
            else if (stall) m_step = m_step;
            else if (e[27]) m_step = 0;
            else if (op == 26 && m_step == 6 && !nz) m_step = 6;
            else m_step = (m_step + 1) % 8;
            m_rf = sr;
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ops[6] = '{12, 13, 3, 26, 8, 31};
        int op;
        void'($urandom(32'd2024));
        // R9 reset state
        cyc(1, 12, 0, 0, 0, 0);
        cyc(1, 12, 1, 1, 1, 0);
        // R1 R2 R3 add with delayed completion
        cyc(0, 12, 0, 0, 0, 0);
        cyc(0, 12, 0, 0, 0, 0);
        cyc(0, 12, 0, 0, 0, 0);
        cyc(0, 12, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 12, 1, 0, 0, 0);
        // R3 immediate add
        for (int i = 0; i < 6; i++) cyc(0, 13, 1, 0, 0, 0);
        // R5 shift: loop three times at step 6
        for (int i = 0; i < 6; i++) cyc(0, 26, 1, 0, 0, 0);
        cyc(0, 26, 1, 0, 0, 0);
        cyc(0, 26, 1, 0, 0, 0);
        cyc(0, 26, 1, 1, 0, 0);
        cyc(0, 26, 1, 1, 0, 0);
        // R5 shift with count zero at step 4
        for (int i = 0; i < 8; i++) cyc(0, 26, 1, 1, 0, 0);
        // R6 branch taken then not taken
        for (int i = 0; i < 5; i++) cyc(0, 8, 1, 0, 1, 0);
        for (int i = 0; i < 5; i++) cyc(0, 8, 1, 0, 0, 0);
        // R4 store with stall at step 7
        for (int i = 0; i < 7; i++) cyc(0, 3, 1, 0, 0, 0);
        cyc(0, 3, 0, 0, 0, 0);
        cyc(0, 3, 0, 0, 0, 0);
        cyc(0, 3, 1, 0, 0, 0);
        // R8 soft reset in the middle of a store
        for (int i = 0; i < 5; i++) cyc(0, 3, 1, 0, 0, 0);
        cyc(0, 3, 1, 0, 0, 1);
        cyc(0, 3, 1, 0, 0, 0);
        cyc(0, 3, 1, 0, 0, 0);
        // R10 unknown opcode
        for (int i = 0; i < 5; i++) cyc(0, 31, 1, 0, 0, 0);
        // random traffic
        op = 12;
        for (int i = 0; i < 4000; i++) begin
            if (m_step == 0 && !m_rf) op = ops[$urandom_range(0, 5)];
            cyc(0, op, ($urandom_range(0, 2) != 0), ($urandom_range(0, 1) == 1),
                ($urandom_range(0, 1) == 1), ($urandom_range(0, 39) == 0));
        end
        // R9 reset in mid sequence
        cyc(1, op, 1, 0, 0, 0);
        cyc(0, op, 1, 0, 0, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule